// File: doc/BRIEF.md
# Round-Robin Supply and Fan Monitor with Limit Interrupts

This block scans a fixed set of measurement channels one after another: voltage rails, one temperature channel and fan tachometer counts. It stores the newest sample of each channel in a result register and compares that sample with a high and a low limit held for that channel. A channel whose sample lies outside its window sets a sticky bit in one of two status registers. A host clears a status register by reading it. A per-source mask keeps chosen status bits away from the interrupt logic. Each of the two interrupt pins also has its own mask bit. The pin stays asserted while any unmasked status bit is set.

The converter is not part of the block. Every channel's current value sits on a parallel sample bus, and the sequencer captures the slice of the channel it has reached. The time spent on each channel comes from the parameter `DWELL_CYC`. A full loop therefore lasts `NUM_CH * (DWELL_CYC + 2)` clock cycles. A large value gives a loop of hundreds of milliseconds, and a small value gives a short loop for simulation. A host reaches the registers through a plain read/write port. Read data is registered.

The sequencer has four states. SEQ_IDLE holds the channel index at 0. SEQ_IDLE goes to SEQ_DWELL when the enable bit is 1. SEQ_DWELL counts `DWELL_CYC` cycles and then goes to SEQ_CAPTURE; it returns to SEQ_IDLE if the enable bit drops. SEQ_CAPTURE stores the sample and always goes to SEQ_CHECK. SEQ_CHECK compares the stored value with its limits and advances the channel. SEQ_CHECK then goes to SEQ_DWELL, or to SEQ_IDLE if the enable bit is 0.

Top module: `hw_monitor`

## Requirements
- R1: After reset the following hold. The configuration register reads 0. Both status registers read 0. Every result reads 0. Every high limit reads FFh and every low limit reads 00h. `irq_a` and `irq_b` are low.
- R2: While bit 0 of the configuration register (address 00h) is 0, the sequencer stays at channel 0 and no result register changes.
- R3: After bit 0 is set, channel 0 is captured first, `DWELL_CYC`+2 cycles after the enable takes effect. Channels then follow in ascending order and wrap from channel `NUM_CH`-1 to channel 0, each taking `DWELL_CYC`+2 cycles.
- R4: The result of channel n reads at address 20h+n. It holds the value of `smp_vals[n*8 +: 8]` at the channel's last capture.
- R5: The high limit of channel n is at 30h+n and the low limit at 40h+n. A channel other than the temperature channel is in violation when its value, taken as unsigned, is greater than the high limit or less than the low limit. A value equal to either limit is not a violation.
- R6: The temperature channel (index `TEMP_CH`, default 6) compares its value and both limits as two's-complement numbers.
- R7: A violation found at the check sets status bit n. Channels 0 to 7 use bit n of status register 01h. Channel 8 uses bit 0 of status register 02h. A set bit stays set while its channel is back in range.
- R8: A read of a status register returns its contents and clears it. A bit set in the same cycle as the read clear stays set.
- R9: The source mask registers 03h and 04h use the same bit layout as the status registers. A mask bit of 1 stops that status bit from driving either interrupt pin, but the status bit is still set.
- R10: Interrupt mask register 05h works as follows. Bit 0 set forces `irq_a` low and bit 1 set forces `irq_b` low. Otherwise a pin goes high one cycle after any unmasked status bit is set.
- R11: Writes to result and status addresses have no effect on what those addresses read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vals | input | NUM_CH*DATA_W | Current sample of every channel, channel n in slice n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 7 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq_a | output | 1 | First interrupt pin |
| irq_b | output | 1 | Second interrupt pin |

## Verification
A result changes at the clock edge that leaves SEQ_CAPTURE. The matching status bit changes one edge later, and the interrupt pins change one edge after the status bit. Read data appears one edge after the read strobe. The bench counts these edges once, for the start-up order check: channel 0 must be visible eleven edges after the enable write, and channel 1 must still hold its old value two edges later. For every other check the bench waits at least two whole loops with the sequencer running. It then stops the sequencer and lets four more edges pass, so every pending capture, check and pin update has settled before a value is read.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_DWELL   = 2'd1,
        SEQ_CAPTURE = 2'd2,
        SEQ_CHECK   = 2'd3
    } seq_state_e;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_CFG      = 7'h00;
    localparam logic [ADDR_W-1:0] A_STAT0    = 7'h01;
    localparam logic [ADDR_W-1:0] A_STAT1    = 7'h02;
    localparam logic [ADDR_W-1:0] A_SMASK0   = 7'h03;
    localparam logic [ADDR_W-1:0] A_SMASK1   = 7'h04;
    localparam logic [ADDR_W-1:0] A_OMASK    = 7'h05;
    localparam logic [ADDR_W-1:0] A_RES_BASE = 7'h20;
    localparam logic [ADDR_W-1:0] A_HI_BASE  = 7'h30;
    localparam logic [ADDR_W-1:0] A_LO_BASE  = 7'h40;

endpackage

// File: rtl/mon_sequencer.sv
module mon_sequencer
    import hwmon_pkg::*;
#(
    parameter int NUM_CH    = 9,
    parameter int DWELL_CYC = 2_000_000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    output logic [$clog2(NUM_CH)-1:0] cur_ch,
    output logic                      cap_stb,
    output logic                      chk_stb
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int CNT_W = $clog2(DWELL_CYC + 1);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DWELL_CYC - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CH_W-1:0]   ch_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (enable) state_d = SEQ_DWELL;
            SEQ_DWELL: begin
                if (!enable)               state_d = SEQ_IDLE;
                else if (cnt_q == LAST_CNT) state_d = SEQ_CAPTURE;
            end
            SEQ_CAPTURE: state_d = SEQ_CHECK;
            SEQ_CHECK:   state_d = enable ? SEQ_DWELL : SEQ_IDLE;
        endcase
    end

    // channel index and dwell counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    ch_q  <= '0;
                    cnt_q <= '0;
                end
                SEQ_DWELL: begin
                    if (!enable) begin
                        ch_q  <= '0;
                        cnt_q <= '0;
                    end else if (cnt_q == LAST_CNT) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_CAPTURE: cnt_q <= '0;
                SEQ_CHECK: begin
                    if (!enable || ch_q == LAST_CH) ch_q <= '0;
                    else                           ch_q <= ch_q + 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        cur_ch  = ch_q;
        cap_stb = (state_q == SEQ_CAPTURE);
        chk_stb = (state_q == SEQ_CHECK);
    end

endmodule

// File: rtl/mon_limit_cmp.sv
module mon_limit_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] hi_lim,
    input  logic [DATA_W-1:0] lo_lim,
    input  logic              is_signed,
    output logic              viol
);
    logic above_u, below_u, above_s, below_s;

    always_comb begin
        above_u = value > hi_lim;
        below_u = value < lo_lim;
        above_s = $signed(value) > $signed(hi_lim);
        below_s = $signed(value) < $signed(lo_lim);
        viol    = is_signed ? (above_s || below_s) : (above_u || below_u);
    end

endmodule

// File: rtl/mon_regs.sv
module mon_regs
    import hwmon_pkg::*;
#(
    parameter int NUM_CH  = 9,
    parameter int DATA_W  = 8,
    parameter int TEMP_CH = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH*DATA_W-1:0]    smp_vals,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    input  logic [$clog2(NUM_CH)-1:0]   cur_ch,
    input  logic                        cap_stb,
    input  logic                        chk_stb,
    output logic                        cfg_en,
    output logic [2*DATA_W-1:0]         status_q,
    output logic [2*DATA_W-1:0]         src_mask,
    output logic [1:0]                  out_mask
);
    localparam int STAT_W = 2 * DATA_W;
    localparam int CH_W   = $clog2(NUM_CH);

    logic [NUM_CH*DATA_W-1:0] res_bus, hi_bus, lo_bus;
    logic [DATA_W-1:0]        sel_res, sel_hi, sel_lo;
    logic                     sel_viol, sel_signed;
    logic [STAT_W-1:0]        set_vec, clr_vec;
    logic [DATA_W-1:0]        rd_val;

    // per-channel result and limit storage
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [DATA_W-1:0] res_q, hi_q, lo_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
                hi_q  <= '1;
                lo_q  <= '0;
            end else begin
                if (cap_stb && cur_ch == CH_W'(i))
                    res_q <= smp_vals[i*DATA_W +: DATA_W];
                if (wr_en && addr == A_HI_BASE + ADDR_W'(i))
                    hi_q <= wdata;
                if (wr_en && addr == A_LO_BASE + ADDR_W'(i))
                    lo_q <= wdata;
            end
        end

        assign res_bus[i*DATA_W +: DATA_W] = res_q;
        assign hi_bus[i*DATA_W +: DATA_W]  = hi_q;
        assign lo_bus[i*DATA_W +: DATA_W]  = lo_q;
    end

    // one comparator shared by all channels
    always_comb begin
        sel_res    = res_bus[cur_ch*DATA_W +: DATA_W];
        sel_hi     = hi_bus[cur_ch*DATA_W +: DATA_W];
        sel_lo     = lo_bus[cur_ch*DATA_W +: DATA_W];
        sel_signed = (cur_ch == CH_W'(TEMP_CH));
    end

    mon_limit_cmp #(.DATA_W(DATA_W)) u_cmp (
        .value     (sel_res),
        .hi_lim    (sel_hi),
        .lo_lim    (sel_lo),
        .is_signed (sel_signed),
        .viol      (sel_viol)
    );

    always_comb begin
        set_vec = (chk_stb && sel_viol) ? (STAT_W'(1) << cur_ch) : '0;
        clr_vec = '0;
        if (rd_en && addr == A_STAT0) clr_vec[DATA_W-1:0]      = '1;
        if (rd_en && addr == A_STAT1) clr_vec[STAT_W-1:DATA_W] = '1;
    end

    // control, status and mask registers; a new set beats a read clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            status_q <= '0;
            src_mask <= '0;
            out_mask <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
            if (wr_en) begin
                if (addr == A_CFG)    cfg_en                   <= wdata[0];
                if (addr == A_SMASK0) src_mask[DATA_W-1:0]     <= wdata;
                if (addr == A_SMASK1) src_mask[STAT_W-1:DATA_W] <= wdata;
                if (addr == A_OMASK)  out_mask                 <= wdata[1:0];
            end
        end
    end

    // read multiplexer
    always_comb begin
        rd_val = '0;
        if (addr == A_CFG)    rd_val = DATA_W'(cfg_en);
        if (addr == A_STAT0)  rd_val = status_q[DATA_W-1:0];
        if (addr == A_STAT1)  rd_val = status_q[STAT_W-1:DATA_W];
        if (addr == A_SMASK0) rd_val = src_mask[DATA_W-1:0];
        if (addr == A_SMASK1) rd_val = src_mask[STAT_W-1:DATA_W];
        if (addr == A_OMASK)  rd_val = DATA_W'(out_mask);
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == A_RES_BASE + ADDR_W'(i)) rd_val = res_bus[i*DATA_W +: DATA_W];
            if (addr == A_HI_BASE + ADDR_W'(i))  rd_val = hi_bus[i*DATA_W +: DATA_W];
            if (addr == A_LO_BASE + ADDR_W'(i))  rd_val = lo_bus[i*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

endmodule

// File: rtl/hw_monitor.sv
module hw_monitor
    import hwmon_pkg::*;
#(
    parameter int NUM_CH    = 9,
    parameter int DATA_W    = 8,
    parameter int DWELL_CYC = 2_000_000,
    parameter int TEMP_CH   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*DATA_W-1:0] smp_vals,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [6:0]               addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     irq_a,
    output logic                     irq_b
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int STAT_W = 2 * DATA_W;

    logic [CH_W-1:0]   cur_ch;
    logic              cap_stb, chk_stb, cfg_en;
    logic [STAT_W-1:0] status_q, src_mask;
    logic [1:0]        out_mask;
    logic              pending;

    mon_sequencer #(.NUM_CH(NUM_CH), .DWELL_CYC(DWELL_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_en),
        .cur_ch  (cur_ch),
        .cap_stb (cap_stb),
        .chk_stb (chk_stb)
    );

    mon_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .TEMP_CH(TEMP_CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vals (smp_vals),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .cur_ch   (cur_ch),
        .cap_stb  (cap_stb),
        .chk_stb  (chk_stb),
        .cfg_en   (cfg_en),
        .status_q (status_q),
        .src_mask (src_mask),
        .out_mask (out_mask)
    );

    assign pending = |(status_q & ~src_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_a <= 1'b0;
            irq_b <= 1'b0;
        end else begin
            irq_a <= pending && !out_mask[0];
            irq_b <= pending && !out_mask[1];
        end
    end

endmodule

// File: rtl/hw_monitor_chk.sv
module hw_monitor_chk
    import hwmon_pkg::*;
#(
    parameter int NUM_CH = 9,
    parameter int DATA_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_en,
    input logic [$clog2(NUM_CH)-1:0] cur_ch,
    input logic                      cap_stb,
    input logic                      chk_stb,
    input logic [2*DATA_W-1:0]       status_q,
    input logic [2*DATA_W-1:0]       src_mask,
    input logic [1:0]                out_mask,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         addr,
    input logic                      irq_a,
    input logic                      irq_b
);
    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    p_hold_ch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !cap_stb) |=> cur_ch == '0);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_stb, chk_stb}));

    p_cap_then_chk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> chk_stb);

    p_ch_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_stb && cfg_en) |=>
            cur_ch == (($past(cur_ch) == LAST_CH) ? '0 : $past(cur_ch) + 1'b1));

    p_set_only_on_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_stb |=> (status_q & ~$past(status_q)) == '0);

    p_sticky_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == A_STAT0) |=>
            (status_q[DATA_W-1:0] & $past(status_q[DATA_W-1:0])) == $past(status_q[DATA_W-1:0]));

    p_sticky_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == A_STAT1) |=>
            (status_q[2*DATA_W-1:DATA_W] & $past(status_q[2*DATA_W-1:DATA_W])) ==
             $past(status_q[2*DATA_W-1:DATA_W]));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STAT0 && !chk_stb) |=> status_q[DATA_W-1:0] == '0);

    p_srcmask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~src_mask) == '0) |=> (!irq_a && !irq_b));

    p_outmask_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask[0] |=> !irq_a);

    p_outmask_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask[1] |=> !irq_b);

    p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(status_q & ~src_mask)) && !out_mask[0]) |=> irq_a);

endmodule

bind hw_monitor hw_monitor_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cur_ch   (cur_ch),
    .cap_stb  (cap_stb),
    .chk_stb  (chk_stb),
    .status_q (status_q),
    .src_mask (src_mask),
    .out_mask (out_mask),
    .rd_en    (rd_en),
    .addr     (addr),
    .irq_a    (irq_a),
    .irq_b    (irq_b)
);

// File: tb/hw_monitor_bench.sv
module hw_monitor_bench;
    localparam int NUM_CH  = 9;
    localparam int DATA_W  = 8;
    localparam int DWELL   = 8;
    localparam int TEMP_CH = 6;
    localparam int SETTLE  = 2 * NUM_CH * (DWELL + 2) + 20;

    // {channel[3:0], value, high, low, expect}
    localparam int NV = 10;
    localparam logic [28:0] VEC [NV] = '{
        {4'd0, 8'h80, 8'h90, 8'h70, 1'b0},
        {4'd0, 8'h91, 8'h90, 8'h70, 1'b1},
        {4'd1, 8'h90, 8'h90, 8'h70, 1'b0},
        {4'd2, 8'h6F, 8'h90, 8'h70, 1'b1},
        {4'd3, 8'h70, 8'h90, 8'h70, 1'b0},
        {4'd6, 8'hF6, 8'h20, 8'hF0, 1'b0},
        {4'd6, 8'h10, 8'h05, 8'hF0, 1'b1},
        {4'd6, 8'hE0, 8'h20, 8'hF0, 1'b1},
        {4'd8, 8'hFF, 8'hC0, 8'h00, 1'b1},
        {4'd7, 8'h00, 8'hFF, 8'h01, 1'b1}
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_CH*DATA_W-1:0] smp_vals = '0;
    logic                     wr_en = 1'b0;
    logic                     rd_en = 1'b0;
    logic [6:0]               addr = '0;
    logic [DATA_W-1:0]        wdata = '0;
    logic [DATA_W-1:0]        rdata;
    logic                     irq_a, irq_b;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    hw_monitor #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DWELL_CYC(DWELL), .TEMP_CH(TEMP_CH)) u_hw_monitor (
        .clk(clk), .rst_n(rst_n), .smp_vals(smp_vals), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic set_val(input int ch, input logic [7:0] v);
        smp_vals[ch*DATA_W +: DATA_W] = v;
    endtask

    function automatic logic [7:0] base_val(input int ch);
        return (ch == TEMP_CH) ? 8'h19 : 8'h40;
    endfunction

    task automatic stop_and_clear();
        logic [7:0] d;
        wr(7'h00, 8'h00);
        idle(4);
        rd(7'h01, d);
        rd(7'h02, d);
    endtask

    task automatic restore_limits(input int ch);
        wr(7'h30 + 7'(ch), (ch == TEMP_CH) ? 8'h7F : 8'hFF);
        wr(7'h40 + 7'(ch), (ch == TEMP_CH) ? 8'h80 : 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(7'h00, d); check("R1 config", d, 8'h00);
        rd(7'h01, d); check("R1 status0", d, 8'h00);
        rd(7'h02, d); check("R1 status1", d, 8'h00);
        rd(7'h20, d); check("R1 result0", d, 8'h00);
        rd(7'h30, d); check("R1 high limit", d, 8'hFF);
        rd(7'h40, d); check("R1 low limit", d, 8'h00);
        check("R1 irq_a", 8'(irq_a), 8'h00);
        check("R1 irq_b", 8'(irq_b), 8'h00);

        // R3 start-up order: channel 0 first, channel 1 later
        restore_limits(TEMP_CH);
        for (int c = 0; c < NUM_CH; c++) set_val(c, base_val(c));
        set_val(0, 8'h11); set_val(1, 8'h22); set_val(2, 8'h33);
        wr(7'h00, 8'h01);
        idle(11);
        rd(7'h20, d); check("R3 channel 0 captured first", d, 8'h11);
        rd(7'h21, d); check("R3 channel 1 not yet captured", d, 8'h00);
        rd(7'h22, d); check("R3 channel 2 not yet captured", d, 8'h00);
        idle(SETTLE);
        rd(7'h21, d); check("R4 channel 1 result", d, 8'h22);
        rd(7'h28, d); check("R4 channel 8 result", d, 8'h40);
        stop_and_clear();

        // R2 disabled sequencer leaves results unchanged
        set_val(0, 8'h5A);
        idle(SETTLE);
        rd(7'h20, d); check("R2 result held while disabled", d, 8'h11);
        // R11 writes to read-only places ignored
        wr(7'h20, 8'hEE);
        rd(7'h20, d); check("R11 result write ignored", d, 8'h11);
        wr(7'h01, 8'hFF);
        rd(7'h01, d); check("R11 status write ignored", d, 8'h00);
        set_val(0, base_val(0)); set_val(1, base_val(1)); set_val(2, base_val(2));

        // R5 R6 R7 R10 vector table
        for (int v = 0; v < NV; v++) begin
            int ch;
            logic [7:0] val, hi, lo;
            logic exp;
            {ch[3:0], val, hi, lo, exp} = {VEC[v][28:25], VEC[v][24:1], VEC[v][0]};
            ch = int'(VEC[v][28:25]);
            stop_and_clear();
            set_val(ch, val);
            wr(7'h30 + 7'(ch), hi);
            wr(7'h40 + 7'(ch), lo);
            wr(7'h00, 8'h01);
            idle(SETTLE);
            wr(7'h00, 8'h00);
            idle(4);
            check("R10 irq_a for vector", 8'(irq_a), 8'(exp));
            check("R10 irq_b for vector", 8'(irq_b), 8'(exp));
            rd((ch < 8) ? 7'h01 : 7'h02, d);
            check((ch == TEMP_CH) ? "R6 signed compare status" : "R5 R7 compare status",
                  8'(d[ch % 8]), 8'(exp));
            rd(7'h20 + 7'(ch), d); check("R4 result for vector", d, val);
            set_val(ch, base_val(ch));
            restore_limits(ch);
        end

        // R7 sticky, R9 source mask, R10 pin masks, R8 read clear
        stop_and_clear();
        set_val(0, 8'h91);
        wr(7'h30, 8'h90);
        wr(7'h00, 8'h01);
        idle(SETTLE);
        set_val(0, base_val(0));
        idle(SETTLE);
        wr(7'h00, 8'h00);
        idle(4);
        check("R7 sticky after return to range irq_a", 8'(irq_a), 8'h01);
        wr(7'h03, 8'h01);
        idle(2);
        check("R9 masked source irq_a", 8'(irq_a), 8'h00);
        check("R9 masked source irq_b", 8'(irq_b), 8'h00);
        wr(7'h03, 8'h00);
        wr(7'h05, 8'h01);
        idle(2);
        check("R10 pin mask a irq_a", 8'(irq_a), 8'h00);
        check("R10 pin mask a irq_b", 8'(irq_b), 8'h01);
        wr(7'h05, 8'h02);
        idle(2);
        check("R10 pin mask b irq_a", 8'(irq_a), 8'h01);
        check("R10 pin mask b irq_b", 8'(irq_b), 8'h00);
        wr(7'h05, 8'h00);
        rd(7'h01, d); check("R8 read returns set bit", d, 8'h01);
        rd(7'h01, d); check("R8 second read cleared", d, 8'h00);
        idle(2);
        check("R8 irq_a drops after clear", 8'(irq_a), 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule